// File: doc/BRIEF.md
# Codec Input Line Steering Unit

This block sits between up to three serial audio codecs and the capture engines of an audio controller. Each codec drives its own serial input line, all clocked by a shared bit clock and framed by a common frame sync pulse. The block passes the incoming bit stream, one bit per clock, to four capture engine outputs. These are grouped into two pairs, and each pair is one PCM-in engine plus one microphone-in engine.

An 8-bit map register picks the routing. With steering off, the three lines are merged by a bitwise OR into one stream that feeds only the first engine pair, and the second pair is idle. With steering on, each pair has its own two-bit field that names the physical line feeding it. A routing change written by software is held back until the next frame sync, so a frame always comes from a single routing.

The block also watches the leading tag bits of every line in each frame. When a codec register read is pending, it records which line answered, so software can discover how the codecs are wired.

Top module: `sdin_line_steer`

## Requirements
- R1: During and after reset the map register reads 0x00, and all engine valid and data outputs are low.
- R2: With steer enable (register bit 3) clear, engine outputs 0 (PCM-in 1) and 1 (mic-in 1) both carry the OR of the three lines, one clock after the bit is presented, with valid high.
- R3: With steer enable clear, engine outputs 2 (PCM-in 2) and 3 (mic-in 2) have valid low and data low, whatever bits 7:6 hold.
- R4: With steer enable set, register bits 5:4 pick the line for outputs 0 and 1: 00 is line 0, 01 is line 1, 10 is line 2.
- R5: With steer enable set, register bits 7:6 pick the line for outputs 2 and 3, using the same codes.
- R6: A select field holding 11 while steer enable is set drives its pair's data to 0 and its valid outputs low.
- R7: A written value can be read back at once, but the data path keeps the old routing until the next clock in which frame sync is high. The bit presented in that clock already uses the new routing.
- R8: Write data in bits 2:0 is ignored. Bit 2 always reads 0, and bits 1:0 read back the last-read-line field.
- R9: At a frame sync with the read-pending input high, if a line's first three bits of the frame just ended were all 1, bits 1:0 take that line's number (00/01/10). If several lines qualify, the lowest-numbered line wins. If no line qualifies, or read-pending is low, the field is unchanged.
- R10: After reset, all valid outputs stay low until the first clock in which frame sync is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High in the clock that carries bit 0 of a frame |
| sdin | input | 3 | Serial data, one bit per codec line |
| rd_pending | input | 1 | A codec register read awaits its return data |
| cfg_we | input | 1 | Map register write strobe |
| cfg_wdata | input | 8 | Map register write data |
| cfg_rdata | output | 8 | Map register read data |
| eng_data | output | 4 | Per-engine serial data: PCM-in 1, mic-in 1, PCM-in 2, mic-in 2 |
| eng_valid | output | 4 | Per-engine valid flags, same order |

## Verification
Assertions check these rules on every clock:
- The second engine pair stays idle while steering is off.
- A reserved select code silences its pair.
- No output is valid before framing is established.
- The merged stream equals the OR of the lines one clock later.
- The last-read-line field never takes the reserved code and moves only on a frame sync with a read pending.
- Written configuration bits read back on the next clock.

Only the bench's scenarios can show the rest:
- The actual routing of each line for each select value.
- The deferral of a routing change to the frame boundary.
- Lowest-line priority when several codecs answer.
- Whether a read with no responder leaves the field alone.

// File: rtl/sdin_steer_pkg.sv
`timescale 1ns/1ps
package sdin_steer_pkg;
  localparam int SEL_W     = 2;
  localparam int NUM_PAIRS = 2;
  localparam int CFG_W     = 1 + NUM_PAIRS * SEL_W;

  typedef logic [SEL_W-1:0] line_sel_t;
  localparam line_sel_t SEL_RSVD = '1;

  // Field order follows register bits 7:3.
  typedef struct packed {
    line_sel_t sel_b;
    line_sel_t sel_a;
    logic      steer;
  } steer_cfg_t;
endpackage

// File: rtl/sdin_steer_cfg.sv
`timescale 1ns/1ps
module sdin_steer_cfg
  import sdin_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_sync,
  input  logic       we,
  input  steer_cfg_t wcfg,
  output steer_cfg_t shadow_o,
  output steer_cfg_t eff_o,
  output logic       locked_o
);
  steer_cfg_t shadow_q;
  steer_cfg_t active_q;
  logic       locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
      locked_q <= 1'b0;
    end else begin
      if (we)
        shadow_q <= wcfg;
      if (frame_sync) begin
        active_q <= shadow_q;
        locked_q <= 1'b1;
      end
    end
  end

  // The bit carried in the sync clock already belongs to the new frame.
  assign eff_o    = frame_sync ? shadow_q : active_q;
  assign locked_o = locked_q | frame_sync;
  assign shadow_o = shadow_q;

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> eff_o == $past(eff_o) || frame_sync);
endmodule

// File: rtl/sdin_steer_pair.sv
`timescale 1ns/1ps
module sdin_steer_pair
  import sdin_steer_pkg::*;
#(
  parameter int NUM_LINES = 3,
  parameter int ENG_PER   = 2,
  parameter bit PRIMARY   = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic               steer_i,
  input  line_sel_t          sel_i,
  input  logic               locked_i,
  output logic [ENG_PER-1:0] data_o,
  output logic [ENG_PER-1:0] vld_o
);
  logic bit_n;
  logic vld_n;
  logic [ENG_PER-1:0] data_q;
  logic [ENG_PER-1:0] vld_q;

  always_comb begin
    bit_n = 1'b0;
    vld_n = 1'b0;
    if (!locked_i) begin
      vld_n = 1'b0;
    end else if (!steer_i) begin
      if (PRIMARY) begin
        vld_n = 1'b1;
        bit_n = |lines_i;
      end
    end else if (int'(sel_i) < NUM_LINES) begin
      vld_n = 1'b1;
      bit_n = lines_i[sel_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      vld_q  <= '0;
    end else begin
      data_q <= {ENG_PER{bit_n}};
      vld_q  <= {ENG_PER{vld_n}};
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  // R10
  no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !locked_i |=> vld_q == '0);

  // R6
  rsvd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (steer_i && sel_i == SEL_RSVD) |=> (vld_q == '0 && data_q == '0));

  generate
    if (PRIMARY) begin : g_pri
      // R2
      or_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_i && !steer_i) |=> (data_q == {ENG_PER{|$past(lines_i)}} && vld_q == '1));
    end else begin : g_sec
      // R3
      sec_off_chk: assert property (@(posedge clk) disable iff (rst)
        !steer_i |=> (vld_q == '0 && data_q == '0));
    end
  endgenerate
endmodule

// File: rtl/sdin_steer_rdtrack.sv
`timescale 1ns/1ps
module sdin_steer_rdtrack
  import sdin_steer_pkg::*;
#(
  parameter int NUM_LINES = 3,
  parameter int TAG_BITS  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_sync,
  input  logic                 rd_pending,
  input  logic [NUM_LINES-1:0] lines_i,
  output line_sel_t            ldi_o
);
  localparam int POS_W = $clog2(TAG_BITS + 1);
  localparam logic [POS_W-1:0] LAST = POS_W'(TAG_BITS - 1);
  localparam logic [POS_W-1:0] DONE = POS_W'(TAG_BITS);

  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    cur_idx;
  logic [TAG_BITS-1:0] tag_q [NUM_LINES];
  logic                full_q;
  line_sel_t           ldi_q;
  line_sel_t           hit_idx;
  logic                hit_any;

  assign cur_idx = frame_sync ? '0 : pos_q;

  // Lowest-numbered responding line has priority.
  always_comb begin
    hit_idx = '0;
    hit_any = 1'b0;
    for (int l = NUM_LINES - 1; l >= 0; l--) begin
      if (&tag_q[l]) begin
        hit_idx = SEL_W'(l);
        hit_any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= DONE;
      full_q <= 1'b0;
      ldi_q  <= '0;
      for (int l = 0; l < NUM_LINES; l++) tag_q[l] <= '0;
    end else begin
      if (cur_idx < DONE) begin
        for (int l = 0; l < NUM_LINES; l++) tag_q[l][cur_idx] <= lines_i[l];
        pos_q <= cur_idx + 1'b1;
      end else begin
        pos_q <= cur_idx;
      end
      full_q <= (cur_idx == LAST) | (full_q & ~frame_sync);
      if (frame_sync && rd_pending && full_q && hit_any)
        ldi_q <= hit_idx;
    end
  end

  assign ldi_o = ldi_q;

  // R9
  ldi_code_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> ldi_q != SEL_RSVD);

  // R9
  ldi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_sync && rd_pending) |=> $stable(ldi_q));
endmodule

// File: rtl/sdin_line_steer.sv
`timescale 1ns/1ps
module sdin_line_steer
  import sdin_steer_pkg::*;
#(
  parameter int NUM_LINES = 3,
  parameter int ENG_PER   = 2,
  parameter int TAG_BITS  = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           frame_sync,
  input  logic [NUM_LINES-1:0]           sdin,
  input  logic                           rd_pending,
  input  logic                           cfg_we,
  input  logic [7:0]                     cfg_wdata,
  output logic [7:0]                     cfg_rdata,
  output logic [NUM_PAIRS*ENG_PER-1:0]   eng_data,
  output logic [NUM_PAIRS*ENG_PER-1:0]   eng_valid
);
  steer_cfg_t shadow;
  steer_cfg_t eff;
  logic       locked;
  line_sel_t  ldi;

  sdin_steer_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .we         (cfg_we),
    .wcfg       (steer_cfg_t'(cfg_wdata[7:8-CFG_W])),
    .shadow_o   (shadow),
    .eff_o      (eff),
    .locked_o   (locked)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      line_sel_t sel_p;
      if (p == 0) begin : g_a
        assign sel_p = eff.sel_a;
      end else begin : g_b
        assign sel_p = eff.sel_b;
      end
      sdin_steer_pair #(
        .NUM_LINES (NUM_LINES),
        .ENG_PER   (ENG_PER),
        .PRIMARY   (p == 0)
      ) u_pair (
        .clk      (clk),
        .rst      (rst),
        .lines_i  (sdin),
        .steer_i  (eff.steer),
        .sel_i    (sel_p),
        .locked_i (locked),
        .data_o   (eng_data[p*ENG_PER +: ENG_PER]),
        .vld_o    (eng_valid[p*ENG_PER +: ENG_PER])
      );
    end
  endgenerate

  sdin_steer_rdtrack #(
    .NUM_LINES (NUM_LINES),
    .TAG_BITS  (TAG_BITS)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .rd_pending (rd_pending),
    .lines_i    (sdin),
    .ldi_o      (ldi)
  );

  assign cfg_rdata = {shadow, 1'b0, ldi};

  // R8
  cfg_wr_back_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata[7:3] == $past(cfg_wdata[7:3]));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (eng_valid == '0 && cfg_rdata == 8'h00));
endmodule

// File: tb/sim_sdin_line_steer.sv
`timescale 1ns/1ps
module sim_sdin_line_steer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_sync = 1'b0;
  logic [2:0] sdin = '0;
  logic       rd_pending = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [3:0] eng_data;
  logic [3:0] eng_valid;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  sdin_line_steer u0 (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .sdin       (sdin),
    .rd_pending (rd_pending),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .eng_data   (eng_data),
    .eng_valid  (eng_valid)
  );

  // {cfg, 0, sdin, expected data, expected valid}
  localparam logic [19:0] VEC [12] = '{
    {8'h00, 1'b0, 3'b001, 4'b0011, 4'b0011},  // R2
    {8'h00, 1'b0, 3'b100, 4'b0011, 4'b0011},  // R2
    {8'h00, 1'b0, 3'b000, 4'b0000, 4'b0011},  // R2 R3
    {8'h08, 1'b0, 3'b001, 4'b1111, 4'b1111},  // R4 R5
    {8'h18, 1'b0, 3'b010, 4'b0011, 4'b1111},  // R4
    {8'h68, 1'b0, 3'b100, 4'b0011, 4'b1111},  // R4 R5
    {8'h68, 1'b0, 3'b010, 4'b1100, 4'b1111},  // R5
    {8'hB8, 1'b0, 3'b111, 4'b1100, 4'b1100},  // R6
    {8'hC8, 1'b0, 3'b001, 4'b0011, 4'b0011},  // R6
    {8'hC0, 1'b0, 3'b010, 4'b0011, 4'b0011},  // R3
    {8'hF0, 1'b0, 3'b000, 4'b0000, 4'b0011},  // R3
    {8'h98, 1'b0, 3'b110, 4'b1111, 4'b1111}   // R4 R5
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic frame(input logic [2:0] b0, input logic [2:0] b1,
                       input logic [2:0] b2, input logic pend);
    frame_sync = 1'b1; rd_pending = pend; sdin = b0; cyc();
    frame_sync = 1'b0; rd_pending = 1'b0; sdin = b1; cyc();
    sdin = b2; cyc();
    sdin = '0; cyc(); cyc();
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cyc(); cyc();
    // R1: state while reset is held
    chk("R1", cfg_rdata, 8'h00);
    chk("R1", {eng_data, eng_valid}, 8'h00);
    rst = 1'b0;
    sdin = 3'b111; cyc(); cyc();
    // R10: no frame sync seen yet
    chk("R10", {4'h0, eng_valid}, 8'h00);
    chk("R10", {4'h0, eng_data}, 8'h00);

    for (int i = 0; i < 12; i++) begin
      cfg_we = 1'b1; cfg_wdata = VEC[i][19:12]; sdin = '0; cyc();
      cfg_we = 1'b0;
      chk("R8", cfg_rdata, {VEC[i][19:15], 3'b000});
      frame_sync = 1'b1; sdin = VEC[i][10:8]; cyc();
      frame_sync = 1'b0;
      chk("R2-R6 data", {4'h0, eng_data}, {4'h0, VEC[i][7:4]});
      chk("R2-R6 valid", {4'h0, eng_valid}, {4'h0, VEC[i][3:0]});
    end

    // R7: active 0x98 (pair A on line 1); write 0x28 mid-frame
    cfg_we = 1'b1; cfg_wdata = 8'h28; sdin = 3'b010; cyc();
    cfg_we = 1'b0;
    chk("R7 readback", cfg_rdata, 8'h28);
    chk("R7 old routing", {6'h0, eng_data[1:0]}, 8'h03);
    sdin = 3'b010; cyc();
    chk("R7 still old", {6'h0, eng_data[1:0]}, 8'h03);
    frame_sync = 1'b1; sdin = 3'b010; cyc();
    frame_sync = 1'b0;
    chk("R7 new at sync", {6'h0, eng_data[1:0]}, 8'h00);
    sdin = 3'b100; cyc();
    chk("R7 new line 2", {6'h0, eng_data[1:0]}, 8'h03);

    // R9: lines 1 and 2 answer, lowest wins
    frame(3'b110, 3'b111, 3'b111, 1'b0);
    chk("R9 before pending", {6'h0, cfg_rdata[1:0]}, 8'h00);
    frame(3'b100, 3'b100, 3'b100, 1'b1);
    chk("R9 lowest wins", {6'h0, cfg_rdata[1:0]}, 8'h01);
    frame(3'b000, 3'b000, 3'b000, 1'b0);
    chk("R9 no pending", {6'h0, cfg_rdata[1:0]}, 8'h01);
    frame(3'b100, 3'b100, 3'b100, 1'b1);
    chk("R9 no responder", {6'h0, cfg_rdata[1:0]}, 8'h01);
    frame(3'b000, 3'b000, 3'b000, 1'b1);
    chk("R9 line 2", {6'h0, cfg_rdata[1:0]}, 8'h02);

    // R8: low bits of write data ignored
    cfg_we = 1'b1; cfg_wdata = 8'hFF; cyc();
    cfg_we = 1'b0;
    chk("R8 ro bits", cfg_rdata, 8'hFA);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule